// File: doc/BRIEF.md
# Multiply-Accumulate Multicycle Processor Core

This block is a small multicycle processor built around one fused multiply-accumulate unit. It holds a program counter, an opcode register, an address register, a memory buffer register and three data registers (X, Y, Z). It computes X + Y*Z into X. A control state machine fetches every instruction word from an external synchronous memory and then runs it as a fixed sequence of register transfers. Each step sets per-register load enables, two-way input selects and an enable that places the memory buffer on the internal bus.

The memory sits outside the block. It has one read latency cycle: it captures the word at `mem_addr` on a clock edge and presents it on `mem_rdata` in the next cycle. The memory writes `mem_wdata` at `mem_addr` on an edge where `mem_we` is high. Programs are made of one-word and two-word instructions. An immediate value or an address always sits in the word right after the opcode. The core raises `halted` when it meets a halt opcode or any opcode it does not define, and it stays halted until the next reset.

Top module: `mac_dsp_core`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `halted` and `mem_we` are 0 and `mem_addr` is 0. Execution begins with a fetch from address 0.
- R2: The opcode sits in bits [3:0] of an instruction word, and bits [15:4] are ignored. Opcode 0 loads X with the word that follows the opcode.
- R3: Opcode 1 loads Y, and opcode 2 loads Z, from the memory address held in bits [7:0] of the following word.
- R4: Opcode 3 is a one-word instruction. It sets X to X + Y*Z, reduced modulo 2^16.
- R5: Opcode 4 writes X to the address in bits [7:0] of the following word. `mem_we` is high for exactly one cycle, and `mem_wdata` holds steady during that cycle.
- R6: Opcode 5 jumps. The next instruction is fetched from the address in bits [7:0] of the following word, and the word after the operand is skipped.
- R7: Opcode 7 halts, and so do opcodes 6 and 8 to 15. After that, `halted` stays 1, `mem_we` stays 0 and `mem_addr` holds steady until reset.
- R8: Each instruction takes a fixed number of cycles, counted from the first fetch cycle. Opcode 0 and opcode 5 take 8 cycles, opcodes 1 and 2 take 11, opcode 3 takes 5 and opcode 4 takes 10. A halting opcode raises `halted` on the 4th clock edge of its fetch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | ADDR_W (8) | Memory address, driven by the address register |
| mem_rdata | input | DATA_W (16) | Memory read data, one cycle after the address |
| mem_wdata | output | DATA_W (16) | Memory write data, driven by the memory buffer register |
| mem_we | output | 1 | Write strobe, registered |
| halted | output | 1 | Registered halt flag, sticky until reset |

## Verification
Every result of this core appears in memory contents or in the cycle in which `halted` rises. Programs are loaded while reset is held. Reset is then released on a falling edge, and the bench counts falling edges until `halted` reads 1. That count must equal the sum of the per-instruction cycle counts plus 4 for the halting fetch. Memory and write-count checks are made only after halt, when every store has finished. The checks after halt sample `mem_addr` and `mem_we` on 20 further falling edges, away from the active edge.

// File: rtl/mac_dsp_pkg.sv
package mac_dsp_pkg;
  localparam int OPC_W = 4;

  localparam logic [OPC_W-1:0] OP_LDX  = 4'd0;
  localparam logic [OPC_W-1:0] OP_LDY  = 4'd1;
  localparam logic [OPC_W-1:0] OP_LDZ  = 4'd2;
  localparam logic [OPC_W-1:0] OP_MAC  = 4'd3;
  localparam logic [OPC_W-1:0] OP_STX  = 4'd4;
  localparam logic [OPC_W-1:0] OP_JMP  = 4'd5;

  typedef enum logic [3:0] {
    S_F_ADDR, S_F_WAIT, S_F_LOAD, S_F_IR,
    S_O_ADDR, S_O_WAIT, S_O_LOAD, S_EXEC,
    S_M_WAIT, S_M_LOAD, S_M_DST,
    S_ST_BUF, S_ST_WR, S_MACC, S_HALT
  } state_t;

  // one enable or select per datapath register
  typedef struct packed {
    logic pc_ld;
    logic pc_sel;   // 0: incrementer, 1: bus
    logic ir_ld;
    logic x_ld;
    logic x_sel;    // 0: bus, 1: mac result
    logic y_ld;
    logic z_ld;
    logic mar_ld;
    logic mar_sel;  // 0: pc, 1: bus
    logic mbr_ld;
    logic mbr_sel;  // 0: memory data, 1: X
    logic mbr_en;   // place mbr on bus
  } ctrl_t;
endpackage

// File: rtl/mac_dsp_reg.sv
module mac_dsp_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  logic         sel,
  input  logic [W-1:0] d0,
  input  logic [W-1:0] d1,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (ld) q <= sel ? d1 : d0;
  end
endmodule

// File: rtl/mac_dsp_mac.sv
module mac_dsp_mac #(
  parameter int W = 16
) (
  input  logic [W-1:0] acc,
  input  logic [W-1:0] mul_a,
  input  logic [W-1:0] mul_b,
  output logic [W-1:0] res
);
  // W-bit context: the sum wraps modulo 2^W
  assign res = acc + mul_a * mul_b;
endmodule

// File: rtl/mac_dsp_datapath.sv
module mac_dsp_datapath
  import mac_dsp_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrl_t             ctl,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [OPC_W-1:0]  ir_op,
  output logic [OPC_W-1:0]  mbr_op
);
  localparam int N_OPND = 2;

  logic [DATA_W-1:0] bus, x_q, mbr_q, mac_res;
  logic [ADDR_W-1:0] pc_q, mar_q;
  logic [DATA_W-1:0] opnd_q [N_OPND];
  logic [N_OPND-1:0] opnd_ld;

  assign bus     = ctl.mbr_en ? mbr_q : '0;
  assign opnd_ld = {ctl.z_ld, ctl.y_ld};

  mac_dsp_reg #(.W(ADDR_W)) u_pc (
    .clk(clk), .rst(rst), .ld(ctl.pc_ld), .sel(ctl.pc_sel),
    .d0(pc_q + ADDR_W'(1)), .d1(bus[ADDR_W-1:0]), .q(pc_q));

  mac_dsp_reg #(.W(OPC_W)) u_ir (
    .clk(clk), .rst(rst), .ld(ctl.ir_ld), .sel(1'b0),
    .d0(bus[OPC_W-1:0]), .d1(bus[OPC_W-1:0]), .q(ir_op));

  mac_dsp_reg #(.W(DATA_W)) u_x (
    .clk(clk), .rst(rst), .ld(ctl.x_ld), .sel(ctl.x_sel),
    .d0(bus), .d1(mac_res), .q(x_q));

  for (genvar g = 0; g < N_OPND; g++) begin : g_opnd
    mac_dsp_reg #(.W(DATA_W)) u_opnd (
      .clk(clk), .rst(rst), .ld(opnd_ld[g]), .sel(1'b0),
      .d0(bus), .d1(bus), .q(opnd_q[g]));
  end

  mac_dsp_reg #(.W(ADDR_W)) u_mar (
    .clk(clk), .rst(rst), .ld(ctl.mar_ld), .sel(ctl.mar_sel),
    .d0(pc_q), .d1(bus[ADDR_W-1:0]), .q(mar_q));

  mac_dsp_reg #(.W(DATA_W)) u_mbr (
    .clk(clk), .rst(rst), .ld(ctl.mbr_ld), .sel(ctl.mbr_sel),
    .d0(mem_rdata), .d1(x_q), .q(mbr_q));

  mac_dsp_mac #(.W(DATA_W)) u_mac (
    .acc(x_q), .mul_a(opnd_q[0]), .mul_b(opnd_q[1]), .res(mac_res));

  assign mem_addr  = mar_q;
  assign mem_wdata = mbr_q;
  assign mbr_op    = mbr_q[OPC_W-1:0];
endmodule

// File: rtl/mac_dsp_ctrl.sv
module mac_dsp_ctrl
  import mac_dsp_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [OPC_W-1:0] ir_op,
  input  logic [OPC_W-1:0] mbr_op,
  output ctrl_t            ctl,
  output logic             mem_we,
  output logic             halted
);
  state_t state_q, nxt;

  always_comb begin
    ctl = '0;
    nxt = state_q;
    case (state_q)
      S_F_ADDR: begin ctl.mar_ld = 1'b1; nxt = S_F_WAIT; end
      S_F_WAIT: begin ctl.pc_ld  = 1'b1; nxt = S_F_LOAD; end
      S_F_LOAD: begin ctl.mbr_ld = 1'b1; nxt = S_F_IR;   end
      S_F_IR: begin
        ctl.ir_ld  = 1'b1;
        ctl.mbr_en = 1'b1;
        case (mbr_op)
          OP_MAC:                                  nxt = S_MACC;
          OP_LDX, OP_LDY, OP_LDZ, OP_STX, OP_JMP:  nxt = S_O_ADDR;
          default:                                 nxt = S_HALT;
        endcase
      end
      S_O_ADDR: begin ctl.mar_ld = 1'b1; nxt = S_O_WAIT; end
      S_O_WAIT: begin ctl.pc_ld  = 1'b1; nxt = S_O_LOAD; end
      S_O_LOAD: begin ctl.mbr_ld = 1'b1; nxt = S_EXEC;   end
      S_EXEC: begin
        ctl.mbr_en = 1'b1;
        case (ir_op)
          OP_LDX: begin ctl.x_ld = 1'b1; nxt = S_F_ADDR; end
          OP_LDY, OP_LDZ: begin
            ctl.mar_ld = 1'b1; ctl.mar_sel = 1'b1; nxt = S_M_WAIT;
          end
          OP_STX: begin
            ctl.mar_ld = 1'b1; ctl.mar_sel = 1'b1; nxt = S_ST_BUF;
          end
          OP_JMP: begin
            ctl.pc_ld = 1'b1; ctl.pc_sel = 1'b1; nxt = S_F_ADDR;
          end
          default: nxt = S_HALT;
        endcase
      end
      S_M_WAIT: nxt = S_M_LOAD;
      S_M_LOAD: begin ctl.mbr_ld = 1'b1; nxt = S_M_DST; end
      S_M_DST: begin
        ctl.mbr_en = 1'b1;
        ctl.y_ld   = (ir_op == OP_LDY);
        ctl.z_ld   = (ir_op == OP_LDZ);
        nxt        = S_F_ADDR;
      end
      S_ST_BUF: begin ctl.mbr_ld = 1'b1; ctl.mbr_sel = 1'b1; nxt = S_ST_WR; end
      S_ST_WR:  nxt = S_F_ADDR;
      S_MACC:   begin ctl.x_ld = 1'b1; ctl.x_sel = 1'b1; nxt = S_F_ADDR; end
      S_HALT:   nxt = S_HALT;
      default:  nxt = S_HALT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_F_ADDR;
      mem_we  <= 1'b0;
      halted  <= 1'b0;
    end else begin
      state_q <= nxt;
      mem_we  <= (nxt == S_ST_WR);
      halted  <= (nxt == S_HALT);
    end
  end
endmodule

// File: rtl/mac_dsp_core.sv
module mac_dsp_core
  import mac_dsp_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              halted
);
  ctrl_t            ctl;
  logic [OPC_W-1:0] ir_op, mbr_op;

  mac_dsp_ctrl u_ctrl (
    .clk(clk), .rst(rst), .ir_op(ir_op), .mbr_op(mbr_op),
    .ctl(ctl), .mem_we(mem_we), .halted(halted));

  mac_dsp_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rst(rst), .ctl(ctl), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .ir_op(ir_op), .mbr_op(mbr_op));
endmodule

// File: rtl/mac_dsp_checker.sv
module mac_dsp_checker #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_we,
  input logic              halted
);
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!halted && !mem_we && mem_addr == '0)); // R1

  AST_WE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we); // R5

  AST_WDATA_HELD: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> $stable(mem_wdata)); // R5

  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted); // R7

  AST_HALT_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    halted |-> !mem_we); // R7

  AST_HALT_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
    halted |=> $stable(mem_addr)); // R7
endmodule

bind mac_dsp_core mac_dsp_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .mem_we(mem_we), .halted(halted));

// File: tb/mac_dsp_core_bench.sv
module mac_dsp_core_bench;
  localparam int  DATA_W = 16;
  localparam int  ADDR_W = 8;
  localparam int  DEPTH  = 1 << ADDR_W;
  localparam time PERIOD = 10ns;
  localparam logic [DATA_W-1:0] FILL = 16'hDEAD;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_rdata;
  logic [DATA_W-1:0] mem_wdata;
  logic              mem_we;
  logic              halted;

  logic              ld_en = 1'b0;
  logic [ADDR_W-1:0] ld_addr = '0;
  logic [DATA_W-1:0] ld_data = '0;
  logic              cnt_clr = 1'b0;
  int                wr_cnt;
  int                n_chk = 0;
  int                n_fail = 0;
  logic [DATA_W-1:0] mem [DEPTH];

  always #(PERIOD/2) clk = ~clk;

  mac_dsp_core #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mac_dsp_core (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .halted(halted));

  // synchronous memory, one cycle read latency, with a loader port
  always @(posedge clk) begin
    if (ld_en)       mem[ld_addr] <= ld_data;
    else if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
    if (cnt_clr)                 wr_cnt <= 0;
    else if (!rst && mem_we)     wr_cnt <= wr_cnt + 1;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic put(int a, logic [DATA_W-1:0] d);
    @(negedge clk);
    ld_en = 1'b1; ld_addr = ADDR_W'(a); ld_data = d;
  endtask

  task automatic wipe();
    rst = 1'b1;
    for (int i = 0; i < DEPTH; i++) put(i, FILL);
    @(negedge clk); ld_en = 1'b0;
  endtask

  // release reset and count cycles until halted
  task automatic run(output int cyc);
    @(negedge clk); ld_en = 1'b0; cnt_clr = 1'b1;
    @(negedge clk); cnt_clr = 1'b0; rst = 1'b0;
    cyc = 0;
    while (!halted && cyc < 2000) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic t_reset();
    wipe();
    put(0, 16'h0007);
    @(negedge clk); ld_en = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 halted in reset", 32'(halted), 0);
    check("R1 we in reset", 32'(mem_we), 0);
    check("R1 addr in reset", 32'(mem_addr), 0);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check("R1 first fetch address", 32'(mem_addr), 0);
    check("R1 halted after release", 32'(halted), 0);
  endtask

  task automatic t_imm_store();
    int cyc;
    wipe();
    put(0, 16'hAB00); put(1, 16'h1234);     // X = 1234, upper opcode bits set
    put(2, 16'h5554); put(3, 16'h0040);     // mem[40] = X
    put(4, 16'h0007);
    run(cyc);
    check("R2 immediate load", 32'(mem[8'h40]), 32'h1234);
    check("R5 single write", 32'(wr_cnt), 1);
    check("R8 cycles imm+store", 32'(cyc), 22);
  endtask

  task automatic t_mac();
    int cyc;
    wipe();
    put(0, 16'h0000); put(1, 16'h0005);
    put(2, 16'h0001); put(3, 16'h0050);
    put(4, 16'h0002); put(5, 16'h0051);
    put(6, 16'h0003);
    put(7, 16'h0004); put(8, 16'h0060);
    put(9, 16'h0007);
    put(8'h50, 16'h0003); put(8'h51, 16'h0007);
    run(cyc);
    check("R3 R4 mac 5+3*7", 32'(mem[8'h60]), 32'h001A);
    check("R8 cycles mac program", 32'(cyc), 49);
  endtask

  task automatic t_mac_wrap();
    int cyc;
    wipe();
    put(0, 16'h0000); put(1, 16'hFFFF);
    put(2, 16'h0001); put(3, 16'h0150);    // address from bits [7:0] only
    put(4, 16'h0002); put(5, 16'h0051);
    put(6, 16'h0003);
    put(7, 16'h0004); put(8, 16'h0061);
    put(9, 16'h0003);
    put(10, 16'h0004); put(11, 16'h0062);
    put(12, 16'h0007);
    put(8'h50, 16'h0101); put(8'h51, 16'h0101);
    run(cyc);
    check("R4 wrap first", 32'(mem[8'h61]), 32'h0200);
    check("R4 wrap second", 32'(mem[8'h62]), 32'h0401);
    check("R3 R5 two writes", 32'(wr_cnt), 2);
    check("R8 cycles wrap program", 32'(cyc), 64);
  endtask

  task automatic t_jump();
    int cyc;
    wipe();
    put(0, 16'h0005); put(1, 16'h0020);
    put(2, 16'h0004); put(3, 16'h0042);     // skipped
    put(8'h20, 16'h0000); put(8'h21, 16'h7777);
    put(8'h22, 16'h0004); put(8'h23, 16'h0041);
    put(8'h24, 16'h0007);
    run(cyc);
    check("R6 target executed", 32'(mem[8'h41]), 32'h7777);
    check("R6 skipped store", 32'(mem[8'h42]), 32'(FILL));
    check("R8 cycles jump program", 32'(cyc), 30);
  endtask

  task automatic t_halt(logic [DATA_W-1:0] opw, int pre_x, int exp_cyc);
    int cyc;
    logic [ADDR_W-1:0] a0;
    int bad;
    wipe();
    if (pre_x != 0) begin
      put(0, 16'h0000); put(1, 16'h4321);
      put(2, opw);
    end else put(0, opw);
    put(pre_x != 0 ? 3 : 1, 16'h0004);
    put(pre_x != 0 ? 4 : 2, 16'h0044);
    run(cyc);
    check("R7 halted raised", 32'(halted), 1);
    check("R8 halt cycles", 32'(cyc), 32'(exp_cyc));
    a0 = mem_addr;
    bad = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (!halted || mem_we || mem_addr !== a0) bad++;
    end
    check("R7 held after halt", 32'(bad), 0);
    check("R7 no write", 32'(wr_cnt), 0);
    check("R7 later store skipped", 32'(mem[8'h44]), 32'(FILL));
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog expired actual running expected done");
    finish_run();
  end

  initial begin
    t_reset();
    t_imm_store();
    t_mac();
    t_mac_wrap();
    t_jump();
    t_halt(16'h0006, 0, 4);
    t_halt(16'h1237, 0, 4);
    t_halt(16'h000F, 1, 12);
    finish_run();
  end
endmodule